// File: doc/BRIEF.md
# Clock Source Selector with Failure Fallback

This block picks the system clock from two sources: an internal oscillator, which is always running, and an external clock. Software picks the source with a select input. The hand-over between the two is glitch-free. The branch that is currently driving is switched off on an edge of its own clock. Only then is the other branch switched on, on an edge of its own clock. Coming out of reset, the internal oscillator drives the output.

The block can also watch the external clock. A toggle flop runs on the external clock, and its value is synchronized into the internal domain. A counter in that domain measures how long it has been since the last toggle. If no toggle arrives for a set number of internal cycles, the block treats the external clock as lost. It then sets a sticky failure flag, which does three things:

- It clears the external branch enable asynchronously, because that clock may never tick again.
- It brings the internal oscillator back in.
- It keeps the external selection locked out until software clears the flag.

The interrupt output follows the flag only while the interrupt is enabled. The oscillators and any PLL are outside the block and appear only as clock inputs.

Top module: `clksel_failover`

## Requirements
- R1: While reset is asserted and right after it, the internal clock drives `clk_sys`, and `src_is_ext`, `fail_flag` and `fail_irq` are all 0.
- R2: With `sel_ext`=1 and no failure pending, `clk_sys` carries the external clock and `src_is_ext` reads 1 within 40 internal cycles. With `sel_ext`=0, it returns to the internal clock and `src_is_ext` reads 0.
- R3: No high or low phase of `clk_sys` is shorter than the shorter half-period of the two inputs. The two branch enables are never on together.
- R4: With `mon_en`=1, the flag is set if the external clock stops for TIMEOUT_CYC internal cycles (plus synchronizer latency of at most 8 cycles). It is never set earlier than TIMEOUT_CYC-3 cycles after the last external edge, and never while the external clock runs. With `mon_en`=0, the flag is never set.
- R5: When `fail_flag` is 1, `clk_sys` runs from the internal clock and `src_is_ext` reads 0 even while `sel_ext`=1.
- R6: `fail_irq` is 1 exactly when `fail_flag` is 1 and `irq_en` is 1.
- R7: `fail_flag` stays 1 until a one-cycle `flag_clr` pulse. After the clear, with the external clock running and `sel_ext`=1, the external clock is selected again.
- R8: If the flag is cleared while the external clock is still stopped, it reads 0 on the next cycle and is set again after another timeout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator; clocks all control logic |
| clk_ext | input | 1 | External clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_ext | input | 1 | Software request: 1 selects external clock |
| mon_en | input | 1 | Enables external clock loss monitoring |
| irq_en | input | 1 | Enables the failure interrupt output |
| flag_clr | input | 1 | One-cycle pulse that clears the failure flag |
| clk_sys | output | 1 | Selected system clock |
| src_is_ext | output | 1 | Status: 1 while the external clock is driving |
| fail_flag | output | 1 | Sticky clock-failure status |
| fail_irq | output | 1 | Failure interrupt request |

## Verification
The assertions are checked on every internal clock edge. They cover five things:

- The two branch enables are never on together.
- A rising failure flag always traces back to a loss event from the monitor.
- The flag holds until cleared, and a clear takes effect on the next cycle.
- The external branch stays off while the flag is set.
- The timeout counter stays within its range.

Some behaviours can only be shown by the bench's scenarios, with timing measured on `clk_sys`:

- the real clock period after each switch;
- the absence of short pulses across every hand-over;
- the earliest and latest point at which a stopped clock is flagged;
- the effect of a clear while the clock is still dead.

These are swept over several external periods and both interrupt enables.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  // saturating increment of the silence counter
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // an edge of the synchronized toggle means the external clock ticked
  function automatic logic toggle_seen(logic newer, logic older);
    return newer ^ older;
  endfunction

  // width needed to hold 0..lim
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/cs_activity_mon.sv
module cs_activity_mon #(
  parameter int unsigned TIMEOUT_CYC = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = clksel_pkg::cnt_width(TIMEOUT_CYC)
) (
  input  logic          clk_int,
  input  logic          clk_ext,
  input  logic          rst_n,
  input  logic          mon_en,
  input  logic          restart,
  output logic          activity,
  output logic          lost_evt,
  output logic [CW-1:0] cnt_q
);
  logic                 ext_tgl;
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) ext_tgl <= 1'b0;
    else        ext_tgl <= ~ext_tgl;
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_tgl};
  end

  assign activity = clksel_pkg::toggle_seen(sync_q[SYNC_STAGES], sync_q[SYNC_STAGES-1]);
  assign lost_evt = mon_en && !activity && !restart && (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!mon_en || activity || restart) cnt_q <= '0;
    else cnt_q <= CW'(clksel_pkg::sat_inc(32'(cnt_q), TIMEOUT_CYC));
  end
endmodule

// File: rtl/cs_gate_branch.sv
module cs_gate_branch #(
  parameter logic RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic en_q,
  output logic busy
);
  logic stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage1_q <= RESET_ON;
    else         stage1_q <= req;
  end

  // second stage on the falling edge: the enable only moves while clk is low
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) en_q <= RESET_ON;
    else         en_q <= stage1_q;
  end

  assign busy = stage1_q | en_q;
endmodule

// File: rtl/cs_failover_ctrl.sv
module cs_failover_ctrl #(
  parameter int unsigned STATUS_SYNC = 2
) (
  input  logic clk_int,
  input  logic rst_n,
  input  logic sel_ext,
  input  logic irq_en,
  input  logic flag_clr,
  input  logic lost_evt,
  input  logic ext_en,
  output logic sel_eff,
  output logic fail_flag,
  output logic fail_irq,
  output logic src_is_ext
);
  import clksel_pkg::*;
  logic [STATUS_SYNC-1:0] st_sync_q;
  clk_src_e               active_src;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)        fail_flag <= 1'b0;
    else if (lost_evt) fail_flag <= 1'b1;
    else if (flag_clr) fail_flag <= 1'b0;
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) st_sync_q <= '0;
    else        st_sync_q <= {st_sync_q[STATUS_SYNC-2:0], ext_en};
  end

  assign active_src = st_sync_q[STATUS_SYNC-1] ? SRC_EXT : SRC_INT;
  assign src_is_ext = (active_src == SRC_EXT);
  assign sel_eff    = sel_ext && !fail_flag;
  assign fail_irq   = fail_flag && irq_en;
endmodule

// File: rtl/clksel_failover.sv
module clksel_failover #(
  parameter int unsigned TIMEOUT_CYC = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sel_ext,
  input  logic mon_en,
  input  logic irq_en,
  input  logic flag_clr,
  output logic clk_sys,
  output logic src_is_ext,
  output logic fail_flag,
  output logic fail_irq
);
  localparam int unsigned CW = clksel_pkg::cnt_width(TIMEOUT_CYC);

  logic          sel_eff;
  logic          int_en, int_busy, ext_en, ext_busy;
  logic          int_req, ext_req, ext_arst_n;
  logic          activity, lost_evt;
  logic [CW-1:0] mon_cnt;

  cs_activity_mon #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .mon_en(mon_en),
    .restart(flag_clr), .activity(activity), .lost_evt(lost_evt), .cnt_q(mon_cnt)
  );

  cs_failover_ctrl #(.STATUS_SYNC(SYNC_STAGES)) u_ctrl (
    .clk_int(clk_int), .rst_n(rst_n), .sel_ext(sel_ext), .irq_en(irq_en),
    .flag_clr(flag_clr), .lost_evt(lost_evt), .ext_en(ext_en), .sel_eff(sel_eff),
    .fail_flag(fail_flag), .fail_irq(fail_irq), .src_is_ext(src_is_ext)
  );

  // each side waits until the other side is fully idle
  assign int_req    = !sel_eff && !ext_busy;
  assign ext_req    = sel_eff && !int_busy;
  // a dead external clock cannot retire its own enable: clear it asynchronously
  assign ext_arst_n = rst_n && !fail_flag;

  cs_gate_branch #(.RESET_ON(1'b1)) u_int_br (
    .clk(clk_int), .arst_n(rst_n), .req(int_req), .en_q(int_en), .busy(int_busy)
  );

  cs_gate_branch #(.RESET_ON(1'b0)) u_ext_br (
    .clk(clk_ext), .arst_n(ext_arst_n), .req(ext_req), .en_q(ext_en), .busy(ext_busy)
  );

  assign clk_sys = (clk_int & int_en) | (clk_ext & ext_en);
endmodule

// File: rtl/clksel_failover_chk.sv
module clksel_failover_chk #(
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned CW = clksel_pkg::cnt_width(TIMEOUT_CYC)
) (
  input logic          clk_int,
  input logic          rst_n,
  input logic          int_en,
  input logic          ext_en,
  input logic          fail_flag,
  input logic          flag_clr,
  input logic          lost_evt,
  input logic [CW-1:0] mon_cnt
);
  p_excl_r3: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(int_en && ext_en));

  p_flag_cause_r4: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(lost_evt));

  p_cnt_bound_r4: assert property (@(posedge clk_int) disable iff (!rst_n)
    mon_cnt <= CW'(TIMEOUT_CYC));

  p_lockout_r5: assert property (@(posedge clk_int) disable iff (!rst_n)
    fail_flag |-> !ext_en);

  p_sticky_r7: assert property (@(posedge clk_int) disable iff (!rst_n)
    (fail_flag && !flag_clr) |=> fail_flag);

  p_clear_r8: assert property (@(posedge clk_int) disable iff (!rst_n)
    (flag_clr && !lost_evt) |=> !fail_flag);
endmodule

bind clksel_failover clksel_failover_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_int(clk_int), .rst_n(rst_n), .int_en(int_en), .ext_en(ext_en),
  .fail_flag(fail_flag), .flag_clr(flag_clr), .lost_evt(lost_evt), .mon_cnt(mon_cnt)
);

// File: tb/clksel_failover_bench.sv
`timescale 1ns/1ps
module clksel_failover_bench;
  localparam int unsigned TOUT = 16;

  logic clk_int = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
  logic sel_ext = 1'b0, mon_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic clk_sys, src_is_ext, fail_flag, fail_irq;

  int  n_chk = 0, n_fail = 0, glitches = 0;
  int  ext_half = 7;
  bit  ext_run = 1'b0, gl_on = 1'b0;
  realtime last_t = 0;

  clksel_failover #(.TIMEOUT_CYC(TOUT)) u_clksel_failover (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .sel_ext(sel_ext),
    .mon_en(mon_en), .irq_en(irq_en), .flag_clr(flag_clr), .clk_sys(clk_sys),
    .src_is_ext(src_is_ext), .fail_flag(fail_flag), .fail_irq(fail_irq)
  );

  always #10 clk_int = ~clk_int;

  always begin
    #(ext_half);
    if (ext_run) clk_ext = ~clk_ext;
    else         clk_ext = 1'b0;
  end

  // R3: width of each phase of clk_sys
  always @(clk_sys) begin
    if (gl_on && ($realtime - last_t) < ((ext_half < 10) ? ext_half : 10) - 0.001)
      glitches++;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_int);
  endtask

  task automatic chk_period(input string req, input int exp_ns);
    realtime t0, t1;
    @(posedge clk_sys); t0 = $realtime;
    @(posedge clk_sys); t1 = $realtime;
    chk((t1 - t0) > exp_ns - 0.5 && (t1 - t0) < exp_ns + 0.5, req, "clk_sys period ns",
        int'(t1 - t0), exp_ns);
    @(negedge clk_int);
  endtask

  task automatic stop_ext();
    @(negedge clk_ext);
    ext_run = 1'b0;
    @(negedge clk_int);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int hs = 0; hs < 4; hs++) begin
      for (int ie = 0; ie < 2; ie++) begin
        gl_on = 1'b0; ext_run = 1'b0; rst_n = 1'b0;
        sel_ext = 1'b0; mon_en = 1'b0; flag_clr = 1'b0; irq_en = ie[0];
        cyc(2);
        ext_half = 7 + 6 * hs;  // 7, 13, 19, 25 ns
        ext_run = 1'b1;
        cyc(3);
        chk(!src_is_ext && !fail_flag && !fail_irq, "R1", "status in reset",
            {src_is_ext, fail_flag, fail_irq}, 0);
        rst_n = 1'b1;
        cyc(4);
        gl_on = 1'b1;
        chk(!src_is_ext && !fail_flag && !fail_irq, "R1", "status after reset",
            {src_is_ext, fail_flag, fail_irq}, 0);
        chk_period("R1", 20);

        // switch to external with monitoring on
        mon_en = 1'b1; sel_ext = 1'b1;
        cyc(40);
        chk(src_is_ext, "R2", "src_is_ext after select", src_is_ext, 1);
        chk_period("R2", 2 * ext_half);
        chk(!fail_flag, "R4", "no flag while ext runs", fail_flag, 0);

        // external clock dies
        stop_ext();
        cyc(TOUT - 3);
        chk(!fail_flag, "R4", "flag not early", fail_flag, 0);
        cyc(11);
        chk(fail_flag, "R4", "flag after timeout", fail_flag, 1);
        cyc(4);
        chk(!src_is_ext, "R5", "fallback status", src_is_ext, 0);
        chk(fail_irq == ie[0], "R6", "irq gated by enable", fail_irq, ie);
        chk_period("R5", 20);

        // clock returns, lockout persists
        ext_run = 1'b1;
        cyc(40);
        chk(fail_flag, "R7", "flag sticky", fail_flag, 1);
        chk(!src_is_ext, "R5", "locked out while flagged", src_is_ext, 0);
        chk_period("R5", 20);

        // clear with live clock returns to external
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        cyc(40);
        chk(!fail_flag && !fail_irq, "R7", "flag cleared", {fail_flag, fail_irq}, 0);
        chk(src_is_ext, "R7", "external reselected", src_is_ext, 1);
        chk_period("R7", 2 * ext_half);

        // clear while still dead
        stop_ext();
        cyc(TOUT + 8);
        chk(fail_flag, "R8", "second failure", fail_flag, 1);
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        cyc(1);
        chk(!fail_flag, "R8", "clear while dead", fail_flag, 0);
        cyc(TOUT + 8);
        chk(fail_flag, "R8", "flag set again", fail_flag, 1);
        chk(!src_is_ext, "R8", "internal kept", src_is_ext, 0);

        // monitoring off: no flag
        mon_en = 1'b0;
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        cyc(3 * TOUT);
        chk(!fail_flag, "R4", "no flag with monitor off", fail_flag, 0);

        // back to internal by software
        ext_run = 1'b1; cyc(5);
        sel_ext = 1'b0;
        cyc(30);
        chk(!src_is_ext, "R2", "deselect status", src_is_ext, 0);
        chk_period("R2", 20);
        chk(glitches == 0, "R3", "short clk_sys phases", glitches, 0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule